// File: doc/BRIEF.md
# Pulse-Coded Gate State Link

This block carries the on/off state of a floating upper gate across an isolation boundary. It sends short event pulses instead of a steady level. The transmitter follows a gate command. Each time the command turns on, it sends one fixed-width pulse on a set line. Each time the command turns off, it sends one fixed-width pulse on a separate clear line. The energy used per transition therefore depends on the pulse width and not on how long the gate stays in one state.

On the far side, a latch takes each set pulse as "turn on" and each clear pulse as "turn off". It holds that state between pulses.

A disable input forces the link to off. A rising edge of disable always sends a clear pulse, even when the latch should already be off. Because the first edge after reset counts as a rising edge when disable is high, the remote latch is set to a known off state at power-up. While disable is high, the command is treated as off. Only one pulse is in flight at a time. A command change that arrives during a pulse is sent as soon as that pulse ends.

Top module: `gateEventLink`

## Requirements
- R1: While reset is asserted (rstN low), both pulse lines and the latched gate output are low.
- R2: When the effective command (cmdIn high and disableIn low, sampled at a clock edge) becomes on while the link is idle, onPulse goes high in the cycle after that edge. It stays high for exactly PULSE_CYCLES cycles and then returns low.
- R3: When the effective command becomes off while the link is idle, offPulse goes high in the cycle after that edge. It stays high for exactly PULSE_CYCLES cycles and then returns low.
- R4: gateHeld goes high in the cycle after a cycle with onPulse high. It goes low in the cycle after a cycle with offPulse high. It does not change in any other cycle.
- R5: onPulse and offPulse are never high in the same cycle.
- R6: If the command changes while a pulse is being sent, that pulse runs its full width. The opposite pulse then starts in the very next cycle, with no gap, so gateHeld ends up matching the command.
- R7: A low-to-high transition of disableIn, or disableIn high at the first edge after reset, always produces an offPulse. This happens even when gateHeld is already low.
- R8: onPulse never starts in a cycle whose preceding edge sampled disableIn high.
- R9: While disableIn stays high, changes of cmdIn produce no pulses and gateHeld stays low. When disableIn falls with cmdIn high, an onPulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdIn | input | 1 | Delayed upper gate command |
| disableIn | input | 1 | Forces the link to off; its rising edge sends a clear pulse |
| onPulse | output | 1 | Set event line, PULSE_CYCLES wide |
| offPulse | output | 1 | Clear event line, PULSE_CYCLES wide |
| gateHeld | output | 1 | Receiver latch state |

## Verification
A wrong count of what has already been sent shows up as a missing pulse or an extra pulse on the next command edge, one cycle after that edge. A counter error shows up as a pulse that is too short or too long. It is visible by the end of the first pulse, and also as a wrong start time for any pulse queued behind it. A bad disable edge detector shows up as no clear pulse in the cycle after disable rises. A bad latch update shows up at gateHeld one cycle after the pulse that should have moved it.

// File: rtl/gel_pkg.sv
package gel_pkg;
  typedef struct packed {
    logic startOn;
    logic startOff;
  } linkStrobeT;
endpackage

// File: rtl/gel_ctrl.sv
module gel_ctrl
  import gel_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdIn,
  input  logic       disableIn,
  input  logic       lineIdle,
  input  logic       lastBeat,
  input  logic       onActive,
  output linkStrobeT strobe
);
  logic sentState;
  logic prevDis;
  logic forcePend;
  logic wantOn;
  logic disRise;
  logic forceNow;
  logic canStart;
  logic canForce;

  assign wantOn   = cmdIn & ~disableIn;
  assign disRise  = disableIn & ~prevDis;
  assign forceNow = forcePend | disRise;
  assign canStart = lineIdle | lastBeat;
  // a forced clear may chain directly after a set pulse, never onto a clear pulse
  assign canForce = lineIdle | (lastBeat & onActive);

  always_comb begin
    strobe = '0;
    if (forceNow) begin
      strobe.startOff = canForce;
    end else if (canStart && (sentState != wantOn)) begin
      strobe.startOn  = wantOn;
      strobe.startOff = ~wantOn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sentState <= 1'b0;
      prevDis   <= 1'b0;
      forcePend <= 1'b0;
    end else begin
      prevDis   <= disableIn;
      forcePend <= forceNow & ~strobe.startOff;
      if (strobe.startOff)     sentState <= 1'b0;
      else if (strobe.startOn) sentState <= 1'b1;
    end
  end
endmodule

// File: rtl/gel_datapath.sv
module gel_datapath
  import gel_pkg::*;
#(
  parameter int PULSE_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  linkStrobeT strobe,
  output logic       onLine,
  output logic       offLine,
  output logic       gateQ,
  output logic       lineIdle,
  output logic       lastBeat
);
  localparam int CNT_W = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CYCLES - 1);

  logic [CNT_W-1:0] beatCnt;
  logic             active;

  assign active   = onLine | offLine;
  assign lineIdle = ~active;
  assign lastBeat = active & (beatCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      onLine  <= 1'b0;
      offLine <= 1'b0;
      beatCnt <= '0;
    end else if (strobe.startOn || strobe.startOff) begin
      onLine  <= strobe.startOn;
      offLine <= strobe.startOff;
      beatCnt <= CNT_LOAD;
    end else if (lastBeat) begin
      onLine  <= 1'b0;
      offLine <= 1'b0;
    end else if (active) begin
      beatCnt <= beatCnt - 1'b1;
    end
  end

  // receiver side: set/clear latch
  always_ff @(posedge clk) begin
    if (!rstN)        gateQ <= 1'b0;
    else if (onLine)  gateQ <= 1'b1;
    else if (offLine) gateQ <= 1'b0;
  end
endmodule

// File: rtl/gateEventLink.sv
module gateEventLink
  import gel_pkg::*;
#(
  parameter int PULSE_CYCLES = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic cmdIn,
  input  logic disableIn,
  output logic onPulse,
  output logic offPulse,
  output logic gateHeld
);
  linkStrobeT strobe;
  logic lineIdle;
  logic lastBeat;

  gel_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .cmdIn(cmdIn), .disableIn(disableIn),
    .lineIdle(lineIdle), .lastBeat(lastBeat), .onActive(onPulse),
    .strobe(strobe)
  );

  gel_datapath #(.PULSE_CYCLES(PULSE_CYCLES)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .onLine(onPulse), .offLine(offPulse), .gateQ(gateHeld),
    .lineIdle(lineIdle), .lastBeat(lastBeat)
  );
endmodule

// File: rtl/gateEventLinkChk.sv
module gateEventLinkChk #(
  parameter int PULSE_CYCLES = 4
) (
  input logic clk,
  input logic rstN,
  input logic disableIn,
  input logic onPulse,
  input logic offPulse,
  input logic gateHeld
);
  int onRun;
  int offRun;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      onRun  <= 0;
      offRun <= 0;
    end else begin
      onRun  <= onPulse  ? onRun + 1  : 0;
      offRun <= offPulse ? offRun + 1 : 0;
    end
  end

  assert_exclusive_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(onPulse && offPulse));
  assert_latch_set_R4: assert property (@(posedge clk) disable iff (!rstN)
    onPulse |=> gateHeld);
  assert_latch_clr_R4: assert property (@(posedge clk) disable iff (!rstN)
    offPulse |=> !gateHeld);
  assert_latch_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!onPulse && !offPulse) |=> $stable(gateHeld));
  assert_on_width_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!onPulse && onRun != 0) |-> onRun == PULSE_CYCLES);
  assert_off_width_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!offPulse && offRun != 0) |-> offRun == PULSE_CYCLES);
  assert_on_max_R2: assert property (@(posedge clk) disable iff (!rstN)
    onRun <= PULSE_CYCLES);
  assert_no_on_disabled_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(onPulse) |-> !$past(disableIn));
endmodule

bind gateEventLink gateEventLinkChk #(.PULSE_CYCLES(PULSE_CYCLES)) uChk (
  .clk(clk), .rstN(rstN), .disableIn(disableIn),
  .onPulse(onPulse), .offPulse(offPulse), .gateHeld(gateHeld)
);

// File: tb/sim_gateEventLink.sv
module sim_gateEventLink;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdIn = 1'b0;
  logic disableIn = 1'b0;
  logic onPulse, offPulse, gateHeld;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // behavioural reference state
  int mRem = 0;
  bit mKind = 1'b0;
  bit mSent = 1'b0;
  bit mForce = 1'b0;
  bit mPrevDis = 1'b0;
  bit mLatch = 1'b0;

  always #10 clk = ~clk;

  gateEventLink #(.PULSE_CYCLES(W)) u0 (
    .clk(clk), .rstN(rstN), .cmdIn(cmdIn), .disableIn(disableIn),
    .onPulse(onPulse), .offPulse(offPulse), .gateHeld(gateHeld)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model, advanced at each rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      mRem = 0; mKind = 0; mSent = 0; mForce = 0; mPrevDis = 0; mLatch = 0;
    end else begin
      bit want, rise, force_, idle, last, startOn, startOff;
      want  = cmdIn && !disableIn;
      rise  = disableIn && !mPrevDis;
      mPrevDis = disableIn;
      if (mRem > 0) mLatch = mKind;
      force_ = mForce || rise;
      idle = (mRem == 0);
      last = (mRem == 1);
      startOn = 0; startOff = 0;
      if (force_) startOff = idle || (last && mKind);
      else if ((idle || last) && (mSent != want)) begin
        startOn = want; startOff = !want;
      end
      mForce = force_ && !startOff;
      if (startOn || startOff) begin
        mRem = W; mKind = startOn; mSent = startOn;
      end else if (mRem > 0) mRem = mRem - 1;
    end
  end

  // compare on every cycle, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      check(onPulse  == (mRem > 0 && mKind),  "R2 onPulse vs model",  onPulse,  (mRem > 0 && mKind));
      check(offPulse == (mRem > 0 && !mKind), "R3 offPulse vs model", offPulse, (mRem > 0 && !mKind));
      check(gateHeld == mLatch,               "R4 gateHeld vs model", gateHeld, mLatch);
      check(!(onPulse && offPulse),           "R5 exclusive lines",   onPulse && offPulse, 0);
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int cnt;
    step(3);
    check(!onPulse && !offPulse && !gateHeld, "R1 reset state", {onPulse, offPulse, gateHeld}, 0);
    rstN = 1'b1;
    step(4);
    check(!onPulse && !offPulse, "R1 quiet after reset", {onPulse, offPulse}, 0);

    // R7: disable rise with latch already off
    disableIn = 1'b1;
    step(1);
    check(offPulse == 1'b1, "R7 forced clear pulse", offPulse, 1);
    step(W + 2);
    disableIn = 1'b0;
    step(2);

    // R2: rising command
    cmdIn = 1'b1;
    step(1);
    check(onPulse == 1'b1, "R2 on pulse starts next cycle", onPulse, 1);
    cnt = 0;
    while (onPulse && cnt < 50) begin cnt++; step(1); end
    check(cnt == W, "R2 on pulse width", cnt, W);
    step(8);
    check(gateHeld == 1'b1, "R4 latch holds on", gateHeld, 1);

    // R3 and R6: fall then rise mid-pulse
    cmdIn = 1'b0;
    step(1);
    check(offPulse == 1'b1, "R3 off pulse starts", offPulse, 1);
    cmdIn = 1'b1;
    cnt = 0;
    while (offPulse && cnt < 50) begin cnt++; step(1); end
    check(cnt == W, "R3 off pulse width", cnt, W);
    check(onPulse == 1'b1, "R6 opposite pulse follows with no gap", onPulse, 1);
    step(W + 2);
    check(gateHeld == 1'b1, "R6 final state matches command", gateHeld, 1);

    // R8 and R9: disable while on, toggle command while disabled
    disableIn = 1'b1;
    step(1);
    check(offPulse == 1'b1, "R7 clear pulse on disable rise", offPulse, 1);
    step(W + 1);
    check(gateHeld == 1'b0, "R9 gate off while disabled", gateHeld, 0);
    cnt = 0;
    for (int i = 0; i < 12; i++) begin
      cmdIn = i[0];
      step(1);
      if (onPulse || offPulse) cnt++;
    end
    check(cnt == 0, "R9 no pulses while disabled", cnt, 0);
    check(gateHeld == 1'b0, "R8 gate still off", gateHeld, 0);
    cmdIn = 1'b1;
    step(1);
    disableIn = 1'b0;
    step(1);
    check(onPulse == 1'b1, "R9 on pulse after disable falls", onPulse, 1);

    // disable raised during an on pulse: on completes, clear follows immediately
    step(1);
    disableIn = 1'b1;
    cnt = 0;
    while (onPulse && cnt < 50) begin cnt++; step(1); end
    check(offPulse == 1'b1, "R6 forced clear after on pulse", offPulse, 1);
    step(W + 2);
    check(gateHeld == 1'b0, "R9 latch off after forced clear", gateHeld, 0);

    // quick command pulses
    disableIn = 1'b0;
    step(2);
    for (int i = 0; i < 20; i++) begin
      cmdIn = ((i % 3) == 0);
      step(1 + (i % 5));
    end
    cmdIn = 1'b0;
    step(3 * W + 4);
    check(gateHeld == 1'b0, "R6 settles to command", gateHeld, 0);

    // reset mid-operation
    cmdIn = 1'b1;
    step(2);
    rstN = 1'b0;
    step(1);
    check(!onPulse && !offPulse && !gateHeld, "R1 reset clears", {onPulse, offPulse, gateHeld}, 0);
    step(2);
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule